// File: doc/BRIEF.md
# Indirect Bank Register Controller

This block sits on the cartridge side of an 8-bit CPU bus and drives two high-order ROM bank address lines. It sees only a few address bits, the ROM-space select, the read/write line, the bus clock phase and two data lanes, the bus bits 5 and 4. Software cannot set the bank in one step. It first writes a value into a staging register. A trigger write then either copies that value into a working register or adds one to the working register, depending on a mode flag. Only a later write into ROM space moves the working value onto the bank pins.

The working register can be read back on the two data lanes. Every other bus bit is left floating. The lanes are returned as a value plus an output-enable, so the pad ring builds the tri-state buffer. All state changes on the falling edge of the bus clock phase.

Top module: `bank_shuffle_ctrl`

## Requirements
- R1: An active-low reset clears the staging register, the working register, the mode flag and the bank pins to zero.
- R2: `data_oe` is high only while `cpu_clk` is high, `rw` is high (read) and the register window is hit. When it is high, `data_out` carries the working register. A read outside the window leaves `data_oe` low.
- R3: A write with select code 2 (`addr1`=1, `addr0`=0) loads `data_in` into the staging register. It changes neither the readback nor the bank pins.
- R4: A write with select code 3 loads data lane 0 (bus bit 4) into the mode flag. 0 selects copy and 1 selects increment.
- R5: A write with select code 0 in copy mode loads the staging register into the working register.
- R6: A write with select code 0 in increment mode adds one to the working register modulo 4, so 3 is followed by 0.
- R7: A write with select code 1 changes no register and no output.
- R8: Any write while `rom_space_n` is low copies the working register to `bank_pins`. Reads in ROM space and register-window writes leave the pins unchanged.
- R9: The window is hit when `addr14`=1, `addr13`=0 and `addr8`=1, so every other address bit is ignored and the window mirrors. Writes that fail this compare have no effect.
- R10: A write that hits both ROM space and the window places the working value from before that write on the pins, while the working register takes its new value.
- R11: A write takes effect at the falling edge of `cpu_clk` that ends its bus cycle. During that cycle's high phase the pins still show the prior value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | Bus clock phase; state updates on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr0 | input | 1 | Address bit 0, register select low bit |
| addr1 | input | 1 | Address bit 1, register select high bit |
| addr8 | input | 1 | Address bit 8, window compare (must be 1) |
| addr13 | input | 1 | Address bit 13, window compare (must be 0) |
| addr14 | input | 1 | Address bit 14, window compare (must be 1) |
| rom_space_n | input | 1 | Low when the CPU addresses ROM space |
| rw | input | 1 | 1 = read, 0 = write |
| data_in | input | BANK_W | Data lanes (bus bits 5:4) |
| data_out | output | BANK_W | Readback value for the data lanes |
| data_oe | output | 1 | Drive enable for the data lanes |
| bank_pins | output | BANK_W | ROM bank address outputs |

## Verification
A trigger write and a pin transfer can happen on the same falling edge when the address lies both in ROM space and in a window mirror, for example 0xC100. The bench first stages a value that differs from the current working value. It then writes to 0xC100 and checks that the pins take the old working value while the readback shows the new one. A plain ROM write after that moves the new value to the pins. A pseudo-random run over mirrored, ROM and outside-window addresses then compares every cycle against a behavioural model, which lets more of these overlaps occur.

// File: rtl/bsc_pkg.sv
package bsc_pkg;

   // Register select carried on address bits 1:0. The codes are decoded
   // directly from the bus, so their values are fixed.
   typedef enum logic [1:0] {
      SEL_TRIGGER = 2'd0,
      SEL_IDLE    = 2'd1,
      SEL_STAGE   = 2'd2,
      SEL_MODE    = 2'd3
   } reg_sel_e;

   // Write strobes produced by the window decoder for one bus cycle.
   typedef struct packed {
      logic stage_we;
      logic mode_we;
      logic trig_we;
      logic idle_we;
      logic rom_we;
   } wr_strobes_t;

   // Mode flag encodings.
   localparam logic MODE_COPY = 1'b0;
   localparam logic MODE_INCR = 1'b1;

endpackage

// File: rtl/bsc_window_dec.sv
module bsc_window_dec
   import bsc_pkg::*;
(
   input  logic        addr0,
   input  logic        addr1,
   input  logic        addr8,
   input  logic        addr13,
   input  logic        addr14,
   input  logic        rom_space_n,
   input  logic        rw,
   output logic        read_hit,
   output wr_strobes_t strobes
);

   logic     win_hit;
   logic     wr_cycle;
   reg_sel_e sel;

   // Only three upper address bits take part in the compare.
   assign win_hit  = addr14 & ~addr13 & addr8;
   assign wr_cycle = ~rw;
   assign sel      = reg_sel_e'({addr1, addr0});
   assign read_hit = rw & win_hit;

   always_comb begin
      strobes          = '0;
      strobes.rom_we   = wr_cycle & ~rom_space_n;
      if (wr_cycle && win_hit) begin
         unique case (sel)
            SEL_TRIGGER: strobes.trig_we  = 1'b1;
            SEL_IDLE:    strobes.idle_we  = 1'b1;
            SEL_STAGE:   strobes.stage_we = 1'b1;
            SEL_MODE:    strobes.mode_we  = 1'b1;
            default:     strobes          = strobes;
         endcase
      end
   end

endmodule

// File: rtl/bsc_state_regs.sv
module bsc_state_regs
   import bsc_pkg::*;
#(
   parameter int BANK_W    = 2,
   parameter int MODE_LANE = 0
) (
   input  logic              cpu_clk,
   input  logic              rst_n,
   input  wr_strobes_t       strobes,
   input  logic [BANK_W-1:0] data_in,
   output logic [BANK_W-1:0] work_q
);

   localparam logic [BANK_W-1:0] STEP = BANK_W'(1);

   logic [BANK_W-1:0] stage_q;
   logic              mode_q;
   logic [BANK_W-1:0] work_next;

   initial begin
      assert (BANK_W >= 1 && BANK_W <= 8)
         else $error("BANK_W out of range");
      assert (MODE_LANE >= 0 && MODE_LANE < BANK_W)
         else $error("MODE_LANE outside data lanes");
   end

   // The sum wraps naturally at 2**BANK_W.
   assign work_next = (mode_q == MODE_INCR) ? (work_q + STEP) : stage_q;

   always_ff @(negedge cpu_clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q <= '0;
         mode_q  <= MODE_COPY;
         work_q  <= '0;
      end else begin
         if (strobes.stage_we) stage_q <= data_in;
         if (strobes.mode_we)  mode_q  <= data_in[MODE_LANE];
         if (strobes.trig_we)  work_q  <= work_next;
      end
   end

   // R3
   stage_load_chk: assert property (@(negedge cpu_clk) disable iff (!rst_n)
      strobes.stage_we |=> (stage_q == $past(data_in)) && $stable(work_q));
   // R4
   mode_load_chk: assert property (@(negedge cpu_clk) disable iff (!rst_n)
      strobes.mode_we |=> mode_q == $past(data_in[MODE_LANE]));
   // R5
   copy_path_chk: assert property (@(negedge cpu_clk) disable iff (!rst_n)
      (strobes.trig_we && mode_q == MODE_COPY) |=> work_q == $past(stage_q));
   // R6
   incr_path_chk: assert property (@(negedge cpu_clk) disable iff (!rst_n)
      (strobes.trig_we && mode_q == MODE_INCR) |=> work_q == BANK_W'($past(work_q) + STEP));
   // R7
   idle_write_chk: assert property (@(negedge cpu_clk) disable iff (!rst_n)
      strobes.idle_we |=> $stable(stage_q) && $stable(mode_q) && $stable(work_q));
   // R9
   one_reg_chk: assert property (@(negedge cpu_clk) disable iff (!rst_n)
      $onehot0({strobes.stage_we, strobes.mode_we, strobes.trig_we, strobes.idle_we}));

endmodule

// File: rtl/bsc_bank_latch.sv
module bsc_bank_latch #(
   parameter int BANK_W = 2
) (
   input  logic              cpu_clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [BANK_W-1:0] d,
   output logic [BANK_W-1:0] q
);

   for (genvar i = 0; i < BANK_W; i++) begin : g_bit
      logic bit_q;
      always_ff @(negedge cpu_clk or negedge rst_n) begin
         if (!rst_n)    bit_q <= 1'b0;
         else if (load) bit_q <= d[i];
      end
      assign q[i] = bit_q;
   end

   // R8
   pin_load_chk: assert property (@(negedge cpu_clk) disable iff (!rst_n)
      load |=> q == $past(d));
   // R8
   pin_hold_chk: assert property (@(negedge cpu_clk) disable iff (!rst_n)
      !load |=> $stable(q));

endmodule

// File: rtl/bank_shuffle_ctrl.sv
module bank_shuffle_ctrl
   import bsc_pkg::*;
#(
   parameter int BANK_W    = 2,
   parameter int MODE_LANE = 0
) (
   input  logic              cpu_clk,
   input  logic              rst_n,
   input  logic              addr0,
   input  logic              addr1,
   input  logic              addr8,
   input  logic              addr13,
   input  logic              addr14,
   input  logic              rom_space_n,
   input  logic              rw,
   input  logic [BANK_W-1:0] data_in,
   output logic [BANK_W-1:0] data_out,
   output logic              data_oe,
   output logic [BANK_W-1:0] bank_pins
);

   wr_strobes_t       strobes;
   logic              read_hit;
   logic [BANK_W-1:0] work_q;

   bsc_window_dec i_dec (
      .addr0       (addr0),
      .addr1       (addr1),
      .addr8       (addr8),
      .addr13      (addr13),
      .addr14      (addr14),
      .rom_space_n (rom_space_n),
      .rw          (rw),
      .read_hit    (read_hit),
      .strobes     (strobes)
   );

   bsc_state_regs #(
      .BANK_W    (BANK_W),
      .MODE_LANE (MODE_LANE)
   ) i_regs (
      .cpu_clk (cpu_clk),
      .rst_n   (rst_n),
      .strobes (strobes),
      .data_in (data_in),
      .work_q  (work_q)
   );

   bsc_bank_latch #(
      .BANK_W (BANK_W)
   ) i_latch (
      .cpu_clk (cpu_clk),
      .rst_n   (rst_n),
      .load    (strobes.rom_we),
      .d       (work_q),
      .q       (bank_pins)
   );

   // Readback drives only during the high phase of a window read.
   assign data_oe  = cpu_clk & read_hit;
   assign data_out = data_oe ? work_q : '0;

   // R10
   overlap_chk: assert property (@(negedge cpu_clk) disable iff (!rst_n)
      (strobes.rom_we && strobes.trig_we) |=> bank_pins == $past(work_q));
   // R2
   oe_dir_chk: assert property (@(posedge cpu_clk) disable iff (!rst_n)
      !rw |-> !data_oe);

endmodule

// File: tb/test_bank_shuffle_ctrl.sv
module test_bank_shuffle_ctrl;

   localparam int BW = 2;
   localparam logic [15:0] PICK [8] = '{16'h4100, 16'h4101, 16'h4102, 16'h4103,
                                        16'h8000, 16'hC100, 16'h4000, 16'h4F03};

   logic          cpu_clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          addr0 = 1'b0, addr1 = 1'b0, addr8 = 1'b0, addr13 = 1'b0, addr14 = 1'b0;
   logic          rom_space_n = 1'b1;
   logic          rw = 1'b1;
   logic [BW-1:0] data_in = '0;
   logic [BW-1:0] data_out;
   logic          data_oe;
   logic [BW-1:0] bank_pins;

   int vecs = 0;
   int errs = 0;
   int m_stage = 0, m_work = 0, m_mode = 0, m_pins = 0;

   always #4 cpu_clk = ~cpu_clk;

   bank_shuffle_ctrl #(.BANK_W(BW), .MODE_LANE(0)) i_bank_shuffle_ctrl (
      .cpu_clk     (cpu_clk),
      .rst_n       (rst_n),
      .addr0       (addr0),
      .addr1       (addr1),
      .addr8       (addr8),
      .addr13      (addr13),
      .addr14      (addr14),
      .rom_space_n (rom_space_n),
      .rw          (rw),
      .data_in     (data_in),
      .data_out    (data_out),
      .data_oe     (data_oe),
      .bank_pins   (bank_pins)
   );

   // One bus cycle: drive in the low phase, check in the high phase,
   // then advance the model to the state after the falling edge.
   task automatic bus(input logic [15:0] a, input bit rd, input logic [7:0] d, input string tag);
      bit hit, bad;
      int exp_oe, old_work;
      @(negedge cpu_clk);
      #1;
      addr0 = a[0]; addr1 = a[1]; addr8 = a[8]; addr13 = a[13]; addr14 = a[14];
      rom_space_n = ~a[15];
      rw = rd;
      data_in = d[5:4];
      @(posedge cpu_clk);
      #2;
      hit = a[14] && !a[13] && a[8];
      exp_oe = (rd && hit) ? 1 : 0;
      vecs++;
      bad = (int'(data_oe) != exp_oe) || (int'(bank_pins) != m_pins) ||
            (exp_oe == 1 && int'(data_out) != m_work);
      if (bad) begin
         errs++;
         $display("FAIL %s addr=%h: oe=%0d data=%0d pins=%0d expected oe=%0d data=%0d pins=%0d",
                  tag, a, data_oe, data_out, bank_pins, exp_oe, m_work, m_pins);
      end
      if (!rst_n) begin
         m_stage = 0; m_work = 0; m_mode = 0; m_pins = 0;
      end else if (!rd) begin
         old_work = m_work;
         if (hit) begin
            case (a[1:0])
               2'd0: m_work = (m_mode != 0) ? (m_work + 1) % 4 : m_stage;
               2'd2: m_stage = int'(d[5:4]);
               2'd3: m_mode = int'(d[4]);
               default: ;
            endcase
         end
         if (a[15]) m_pins = old_work;
      end
   endtask

   initial begin : watchdog
      #(200000 * 8);
      errs++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end

   initial begin : stim
      logic [15:0] lf;
      // R1: reset state, also with writes attempted during reset
      bus(16'h4100, 1'b1, 8'h00, "R1");
      bus(16'h4102, 1'b0, 8'h30, "R1");
      bus(16'h8000, 1'b0, 8'h00, "R1");
      rst_n = 1'b1;
      bus(16'h4100, 1'b1, 8'h00, "R1");
      // R2: readback and outside-window read
      bus(16'h4103, 1'b1, 8'h00, "R2");
      bus(16'h4000, 1'b1, 8'h00, "R2");
      // R3: staging is invisible
      bus(16'h4102, 1'b0, 8'h20, "R3");
      bus(16'h4100, 1'b1, 8'h00, "R3");
      // R5: copy into working
      bus(16'h4100, 1'b0, 8'h00, "R5");
      bus(16'h4100, 1'b1, 8'h00, "R5");
      // R8 and R11: ROM write, pins old during its own high phase
      bus(16'h8000, 1'b0, 8'h00, "R11");
      bus(16'h8000, 1'b1, 8'h00, "R8");
      bus(16'hFFFF, 1'b1, 8'h00, "R8");
      // R4 and R6: increment mode with wrap
      bus(16'h4103, 1'b0, 8'h10, "R4");
      bus(16'h4100, 1'b0, 8'h00, "R6");
      bus(16'h4100, 1'b1, 8'h00, "R6");
      bus(16'h4100, 1'b0, 8'h00, "R6");
      bus(16'h4100, 1'b1, 8'h00, "R6");
      bus(16'h4100, 1'b0, 8'h00, "R6");
      bus(16'h4100, 1'b1, 8'h00, "R6");
      // R7: idle register
      bus(16'h4101, 1'b0, 8'h30, "R7");
      bus(16'h4100, 1'b1, 8'h00, "R7");
      bus(16'hA000, 1'b0, 8'h00, "R7");
      // R9: mirrors and near misses
      bus(16'h4F02, 1'b0, 8'h30, "R9");
      bus(16'h5103, 1'b0, 8'h00, "R9");
      bus(16'h41FC, 1'b0, 8'h00, "R9");
      bus(16'h41FC, 1'b1, 8'h00, "R9");
      bus(16'h4002, 1'b0, 8'h10, "R9");
      bus(16'h6100, 1'b0, 8'h00, "R9");
      bus(16'h0100, 1'b0, 8'h00, "R9");
      bus(16'h4100, 1'b1, 8'h00, "R9");
      // R10: trigger and pin transfer on the same edge
      bus(16'h4102, 1'b0, 8'h10, "R10");
      bus(16'hC100, 1'b0, 8'h00, "R10");
      bus(16'h4100, 1'b1, 8'h00, "R10");
      bus(16'h8000, 1'b0, 8'h00, "R10");
      bus(16'h4100, 1'b1, 8'h00, "R10");
      // Pseudo-random mix
      lf = 16'hACE1;
      for (int i = 0; i < 400; i++) begin
         bus(PICK[lf[2:0]], lf[3], lf[15:8], "R2/R5/R6/R8 mix");
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      end
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end

endmodule